// File: doc/BRIEF.md
# Receiver PHY bring-up sequencer

This block brings a multi-lane high-speed receiver PHY from reset to normal operation without software involvement. It is given a lane count and a line rate in Mbps. The rate is translated into a frequency band code by a range lookup. On a start pulse the block programs the PHY control fields, then pulses the PHY test-clear line with timed waits on both sides. After that it replays a fixed list of test-port register writes that load the band code and the settle time. A single-cycle done pulse ends the sequence.

The control field outputs, the test-clear line and the test port (clock, enable, 8-bit data) connect straight to the PHY. A separate power-off request clears the lane enables at any time. A request with an unsupported rate or lane count is refused with a reject pulse and changes nothing.

Top module: `rx_phy_bringup`

## Requirements
- R1: Out of reset, busy, done and reject are low, every control field is zero, and the test clock, test-clear, test-enable and test data are all zero.
- R2: The band is the first entry of the ascending range table whose upper bound (Mbps) is at least the rate. Examples: 0 to 89 gives 0x00, 90 gives 0x10, 109 gives 0x20, 110 gives 0x01, 300 gives 0x05, 800 gives 0x29, 1000 gives 0x2A, 1200 gives 0x2B, 1500 gives 0x3C.
- R3: A start with a rate above 1500 Mbps, or with a lane count outside 1 to 4, raises reject_o for one cycle one clock later. busy_o stays low and no field or test-port output changes.
- R4: One clock after an accepted start: busy_o is high; force-receive, force-stop and turn-request are 0; turn-disable is 0xF; lane enable has bits [N-1:0] set for N lanes; the test clock and test-clear are high.
- R5: Test-clear stays high for exactly CLK_KHZ*CLEAR_US/1000 cycles. After it falls, the test port holds still for at least as many cycles again.
- R6: Seven test-port writes follow, each given as (code, data): (0x34, 0x00), then (0x44, 0x54, 0x84, 0x94, each with band<<1), then (0x75, 0x04), then (0x00, 0x00). The code is the value on the data bus when the test clock falls. The data is the value on the bus when the test clock rises.
- R7: Each write runs six steps: drive the code, raise enable, lower the test clock, lower enable, drive the data, raise the test clock. Each step lasts STEP_CYCLES cycles. Enable is high at the clock's falling edge and low at its rising edge.
- R8: done_o pulses for one cycle, in the cycle busy_o falls, once the last write's clock-high step has ended. The lane enable stays at its mask afterwards.
- R9: A start while busy_o is high is ignored. The running sequence keeps its band, its lane mask and its seven writes.
- R10: power_off_i sets lane enable to 0 in the next cycle, whatever the state. It wins over the enable written by a start in the same cycle. A running sequence continues to done.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| lanes_i | input | 3 | Requested lane count |
| rate_mbps_i | input | 11 | Requested line rate in Mbps |
| power_off_i | input | 1 | Clears the lane enables |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | One-cycle refusal pulse |
| force_rx_o | output | 4 | Per-lane force-receive field |
| force_stop_o | output | 4 | Per-lane force-stop field |
| turn_req_o | output | 4 | Per-lane turnaround request field |
| turn_dis_o | output | 4 | Per-lane turnaround disable field |
| lane_en_o | output | 4 | Per-lane enable field |
| tst_clk_o | output | 1 | Test port clock |
| tst_clr_o | output | 1 | Test port clear |
| tst_en_o | output | 1 | Test port enable |
| tst_din_o | output | 8 | Test port code/data bus |

## Verification
Two actions can land on the lane-enable field in the same cycle. One is the enable mask written by an accepted start. The other is a power-off request. The bench raises start and power-off on the same clock and expects lane enable to read 0 while the sequence still runs to done. A start is also pulsed in the middle of a running sequence. The bench expects no reject, no restart, and the original lane mask and band code in the recorded test-port writes.

// File: rtl/rxpb_pkg.sv
package rxpb_pkg;

    localparam int LANES      = 4;
    localparam int LANE_CNT_W = $clog2(LANES + 1);
    localparam int RATE_W     = 11;
    localparam int BAND_W     = 7;
    localparam int N_BANDS    = 39;
    localparam int N_WR       = 7;
    localparam int WR_IDX_W   = $clog2(N_WR);

    typedef struct packed {
        logic [RATE_W-1:0] top_mbps;
        logic [BAND_W-1:0] code;
    } band_ent_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLR_ON,
        SQ_CLR_OFF,
        SQ_WRITE,
        SQ_WAIT_ACK
    } sq_state_e;

    typedef enum logic [2:0] {
        TP_IDLE,
        TP_CODE,
        TP_EN_HI,
        TP_CLK_LO,
        TP_EN_LO,
        TP_DATA,
        TP_CLK_HI
    } tp_step_e;

    // Ascending band ranges: an entry covers rates up to and including top_mbps
    function automatic band_ent_t band_entry(input int idx);
        case (idx)
            0:  band_entry = {11'd89,   7'h00};
            1:  band_entry = {11'd99,   7'h10};
            2:  band_entry = {11'd109,  7'h20};
            3:  band_entry = {11'd129,  7'h01};
            4:  band_entry = {11'd139,  7'h11};
            5:  band_entry = {11'd149,  7'h21};
            6:  band_entry = {11'd169,  7'h02};
            7:  band_entry = {11'd179,  7'h12};
            8:  band_entry = {11'd199,  7'h22};
            9:  band_entry = {11'd219,  7'h03};
            10: band_entry = {11'd239,  7'h13};
            11: band_entry = {11'd249,  7'h23};
            12: band_entry = {11'd269,  7'h04};
            13: band_entry = {11'd299,  7'h14};
            14: band_entry = {11'd329,  7'h05};
            15: band_entry = {11'd359,  7'h15};
            16: band_entry = {11'd399,  7'h25};
            17: band_entry = {11'd449,  7'h06};
            18: band_entry = {11'd499,  7'h16};
            19: band_entry = {11'd549,  7'h07};
            20: band_entry = {11'd599,  7'h17};
            21: band_entry = {11'd649,  7'h08};
            22: band_entry = {11'd699,  7'h18};
            23: band_entry = {11'd749,  7'h09};
            24: band_entry = {11'd799,  7'h19};
            25: band_entry = {11'd849,  7'h29};
            26: band_entry = {11'd899,  7'h39};
            27: band_entry = {11'd949,  7'h0a};
            28: band_entry = {11'd999,  7'h1a};
            29: band_entry = {11'd1049, 7'h2a};
            30: band_entry = {11'd1099, 7'h3a};
            31: band_entry = {11'd1149, 7'h0b};
            32: band_entry = {11'd1199, 7'h1b};
            33: band_entry = {11'd1249, 7'h2b};
            34: band_entry = {11'd1299, 7'h3b};
            35: band_entry = {11'd1349, 7'h0c};
            36: band_entry = {11'd1399, 7'h1c};
            37: band_entry = {11'd1449, 7'h2c};
            default: band_entry = {11'd1500, 7'h3c};
        endcase
    endfunction

    // Test-port script: register code per step (order is behaviour)
    function automatic logic [7:0] wr_code(input logic [WR_IDX_W-1:0] idx);
        case (idx)
            3'd0:    wr_code = 8'h34;
            3'd1:    wr_code = 8'h44;
            3'd2:    wr_code = 8'h54;
            3'd3:    wr_code = 8'h84;
            3'd4:    wr_code = 8'h94;
            3'd5:    wr_code = 8'h75;
            default: wr_code = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] wr_data(input logic [WR_IDX_W-1:0] idx,
                                           input logic [BAND_W-1:0]   band);
        case (idx)
            3'd1, 3'd2, 3'd3, 3'd4: wr_data = {band, 1'b0};
            3'd5:                   wr_data = 8'h04;
            default:                wr_data = 8'h00;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [LANE_CNT_W-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (LANE_CNT_W'(i) < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/rxpb_band_map.sv
module rxpb_band_map
    import rxpb_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    output logic              hit_o,
    output logic [BAND_W-1:0] band_o
);

    band_ent_t ent;

    // Walk from the top entry down so the lowest matching entry wins
    always_comb begin
        hit_o  = 1'b0;
        band_o = '0;
        ent    = '0;
        for (int i = N_BANDS - 1; i >= 0; i--) begin
            ent = band_entry(i);
            if (rate_i <= ent.top_mbps) begin
                hit_o  = 1'b1;
                band_o = ent.code;
            end
        end
    end

endmodule

// File: rtl/rxpb_tport.sv
module rxpb_tport
    import rxpb_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clk_set_i,
    input  logic       go_i,
    input  logic [7:0] code_i,
    input  logic [7:0] data_i,
    output logic       tclk_o,
    output logic       ten_o,
    output logic [7:0] tdin_o,
    output logic       ack_o
);

    localparam int HOLD   = (STEP_CYCLES < 1) ? 1 : STEP_CYCLES;
    localparam int HCNT_W = $clog2(HOLD + 1);
    localparam logic [HCNT_W-1:0] HOLD_M1 = HCNT_W'(HOLD - 1);

    typedef struct packed {
        tp_step_e          step;
        logic [HCNT_W-1:0] hcnt;
        logic              tclk;
        logic              ten;
        logic [7:0]        tdin;
        logic              ack;
    } tp_regs_t;

    tp_regs_t q, d;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        if (q.step == TP_IDLE) begin
            if (clk_set_i) begin
                d.tclk = 1'b1;
            end
            if (go_i) begin
                d.step = TP_CODE;
                d.tdin = code_i;
                d.hcnt = HOLD_M1;
            end
        end else if (q.hcnt != '0) begin
            d.hcnt = q.hcnt - 1'b1;
        end else begin
            d.hcnt = HOLD_M1;
            case (q.step)
                TP_CODE: begin
                    d.ten  = 1'b1;
                    d.step = TP_EN_HI;
                end
                TP_EN_HI: begin
                    d.tclk = 1'b0;
                    d.step = TP_CLK_LO;
                end
                TP_CLK_LO: begin
                    d.ten  = 1'b0;
                    d.step = TP_EN_LO;
                end
                TP_EN_LO: begin
                    d.tdin = data_i;
                    d.step = TP_DATA;
                end
                TP_DATA: begin
                    d.tclk = 1'b1;
                    d.step = TP_CLK_HI;
                end
                TP_CLK_HI: begin
                    d.ack  = 1'b1;
                    d.step = TP_IDLE;
                end
                default: d.step = TP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{step: TP_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign tclk_o = q.tclk;
    assign ten_o  = q.ten;
    assign tdin_o = q.tdin;
    assign ack_o  = q.ack;

endmodule

// File: rtl/rxpb_seq.sv
module rxpb_seq
    import rxpb_pkg::*;
#(
    parameter int CLK_KHZ  = 125000,
    parameter int CLEAR_US = 100
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [LANE_CNT_W-1:0] lanes_i,
    input  logic                  power_off_i,
    input  logic                  hit_i,
    input  logic [BAND_W-1:0]     band_i,
    input  logic                  tp_ack_i,
    output logic                  tp_go_o,
    output logic [7:0]            tp_code_o,
    output logic [7:0]            tp_data_o,
    output logic                  tclk_set_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  reject_o,
    output logic                  clr_o,
    output logic [LANES-1:0]      force_rx_o,
    output logic [LANES-1:0]      force_stop_o,
    output logic [LANES-1:0]      turn_req_o,
    output logic [LANES-1:0]      turn_dis_o,
    output logic [LANES-1:0]      lane_en_o
);

    localparam int WAIT_RAW = (CLK_KHZ * CLEAR_US) / 1000;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int WCNT_W   = $clog2(WAIT_CYC + 1);
    localparam logic [WCNT_W-1:0] WAIT_M1 = WCNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        sq_state_e           st;
        logic [WCNT_W-1:0]   wcnt;
        logic [WR_IDX_W-1:0] idx;
        logic [BAND_W-1:0]   band;
        logic                busy;
        logic                done;
        logic                reject;
        logic                clr;
        logic [LANES-1:0]    frx;
        logic [LANES-1:0]    fstop;
        logic [LANES-1:0]    treq;
        logic [LANES-1:0]    tdis;
        logic [LANES-1:0]    len;
    } sq_regs_t;

    sq_regs_t q, d;
    logic     lanes_ok;
    logic     accept;

    assign lanes_ok = (lanes_i != '0) && (lanes_i <= LANE_CNT_W'(LANES));
    assign accept   = (q.st == SQ_IDLE) && start_i && hit_i && lanes_ok;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.reject = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (accept) begin
                    d.st    = SQ_CLR_ON;
                    d.wcnt  = WAIT_M1;
                    d.band  = band_i;
                    d.busy  = 1'b1;
                    d.clr   = 1'b1;
                    d.frx   = '0;
                    d.fstop = '0;
                    d.treq  = '0;
                    d.tdis  = '1;
                    d.len   = lane_mask(lanes_i);
                end else if (start_i) begin
                    d.reject = 1'b1;
                end
            end
            SQ_CLR_ON: begin
                if (q.wcnt == '0) begin
                    d.clr  = 1'b0;
                    d.wcnt = WAIT_M1;
                    d.st   = SQ_CLR_OFF;
                end else begin
                    d.wcnt = q.wcnt - 1'b1;
                end
            end
            SQ_CLR_OFF: begin
                if (q.wcnt == '0) begin
                    d.idx = '0;
                    d.st  = SQ_WRITE;
                end else begin
                    d.wcnt = q.wcnt - 1'b1;
                end
            end
            SQ_WRITE: begin
                d.st = SQ_WAIT_ACK;
            end
            SQ_WAIT_ACK: begin
                if (tp_ack_i) begin
                    if (q.idx == WR_IDX_W'(N_WR - 1)) begin
                        d.st   = SQ_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = SQ_WRITE;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        // Power-off has the last word on the lane enables
        if (power_off_i) begin
            d.len = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: SQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign tp_go_o      = (q.st == SQ_WRITE);
    assign tp_code_o    = wr_code(q.idx);
    assign tp_data_o    = wr_data(q.idx, q.band);
    assign tclk_set_o   = accept;
    assign busy_o       = q.busy;
    assign done_o       = q.done;
    assign reject_o     = q.reject;
    assign clr_o        = q.clr;
    assign force_rx_o   = q.frx;
    assign force_stop_o = q.fstop;
    assign turn_req_o   = q.treq;
    assign turn_dis_o   = q.tdis;
    assign lane_en_o    = q.len;

endmodule

// File: rtl/rx_phy_bringup.sv
module rx_phy_bringup
    import rxpb_pkg::*;
#(
    parameter int CLK_KHZ     = 125000,
    parameter int CLEAR_US    = 100,
    parameter int STEP_CYCLES = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [2:0]  lanes_i,
    input  logic [10:0] rate_mbps_i,
    input  logic        power_off_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        reject_o,
    output logic [3:0]  force_rx_o,
    output logic [3:0]  force_stop_o,
    output logic [3:0]  turn_req_o,
    output logic [3:0]  turn_dis_o,
    output logic [3:0]  lane_en_o,
    output logic        tst_clk_o,
    output logic        tst_clr_o,
    output logic        tst_en_o,
    output logic [7:0]  tst_din_o
);

    logic              hit;
    logic [BAND_W-1:0] band;
    logic              tp_go;
    logic              tp_ack;
    logic              tclk_set;
    logic [7:0]        tp_code;
    logic [7:0]        tp_data;

    rxpb_band_map u_band (
        .rate_i (rate_mbps_i),
        .hit_o  (hit),
        .band_o (band)
    );

    rxpb_seq #(
        .CLK_KHZ  (CLK_KHZ),
        .CLEAR_US (CLEAR_US)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .lanes_i      (lanes_i),
        .power_off_i  (power_off_i),
        .hit_i        (hit),
        .band_i       (band),
        .tp_ack_i     (tp_ack),
        .tp_go_o      (tp_go),
        .tp_code_o    (tp_code),
        .tp_data_o    (tp_data),
        .tclk_set_o   (tclk_set),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .reject_o     (reject_o),
        .clr_o        (tst_clr_o),
        .force_rx_o   (force_rx_o),
        .force_stop_o (force_stop_o),
        .turn_req_o   (turn_req_o),
        .turn_dis_o   (turn_dis_o),
        .lane_en_o    (lane_en_o)
    );

    rxpb_tport #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_tport (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clk_set_i (tclk_set),
        .go_i      (tp_go),
        .code_i    (tp_code),
        .data_i    (tp_data),
        .tclk_o    (tst_clk_o),
        .ten_o     (tst_en_o),
        .tdin_o    (tst_din_o),
        .ack_o     (tp_ack)
    );

endmodule

// File: rtl/rx_phy_bringup_chk.sv
module rx_phy_bringup_chk #(
    parameter int STEP_CYCLES = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       power_off_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       reject_o,
    input logic [3:0] turn_dis_o,
    input logic [3:0] lane_en_o,
    input logic       tst_clk_o,
    input logic       tst_clr_o,
    input logic       tst_en_o,
    input logic [7:0] tst_din_o
);

    localparam int CW = $clog2(STEP_CYCLES + 2) + 1;

    logic [9:0]    port_prev_q;
    logic [CW-1:0] run_q;
    logic [9:0]    port_now;

    assign port_now = {tst_clk_o, tst_en_o, tst_din_o};

    // Cycles the test port has held its present value
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            port_prev_q <= '0;
            run_q       <= '1;
        end else begin
            port_prev_q <= port_now;
            if (port_now != port_prev_q) begin
                run_q <= CW'(1);
            end else if (run_q != '1) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    a_r3_reject_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reject_o |-> !busy_o);

    a_r4_fields_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (turn_dis_o == 4'hF) && tst_clk_o && tst_clr_o);

    a_r4_lane_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) && !$past(power_off_i) |->
            (lane_en_o == 4'h1) || (lane_en_o == 4'h3) ||
            (lane_en_o == 4'h7) || (lane_en_o == 4'hF));

    a_r5_clr_under_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tst_clr_o |-> tst_clk_o && busy_o && !tst_en_o);

    a_r7_en_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tst_clk_o) |-> tst_en_o);

    a_r7_en_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tst_clk_o) |-> !tst_en_o);

    a_r7_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && !tst_clr_o && !$past(tst_clr_o) &&
        (port_now != port_prev_q) |-> run_q >= CW'(STEP_CYCLES));

    a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && $past(busy_o));

    a_r10_power_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        power_off_i |=> lane_en_o == 4'h0);

endmodule

bind rx_phy_bringup rx_phy_bringup_chk #(
    .STEP_CYCLES (STEP_CYCLES)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .power_off_i (power_off_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .reject_o    (reject_o),
    .turn_dis_o  (turn_dis_o),
    .lane_en_o   (lane_en_o),
    .tst_clk_o   (tst_clk_o),
    .tst_clr_o   (tst_clr_o),
    .tst_en_o    (tst_en_o),
    .tst_din_o   (tst_din_o)
);

// File: tb/rx_phy_bringup_bench.sv
module rx_phy_bringup_bench;

    localparam int CLK_KHZ  = 125000;
    localparam int CLEAR_US = 2;
    localparam int STEP     = 3;
    localparam int WAIT_CYC = CLK_KHZ * CLEAR_US / 1000;

    typedef struct packed {
        logic [2:0]  lanes;
        logic [10:0] rate;
        logic        accept;
        logic [6:0]  band;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd1, 11'd50,   1'b1, 7'h00},
        '{3'd2, 11'd89,   1'b1, 7'h00},
        '{3'd3, 11'd90,   1'b1, 7'h10},
        '{3'd4, 11'd109,  1'b1, 7'h20},
        '{3'd1, 11'd110,  1'b1, 7'h01},
        '{3'd2, 11'd800,  1'b1, 7'h29},
        '{3'd4, 11'd1500, 1'b1, 7'h3c},
        '{3'd3, 11'd1501, 1'b0, 7'h00},
        '{3'd0, 11'd500,  1'b0, 7'h00},
        '{3'd5, 11'd500,  1'b0, 7'h00},
        '{3'd4, 11'd1000, 1'b1, 7'h2a}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  lanes = '0;
    logic [10:0] rate = '0;
    logic        power_off = 1'b0;
    logic        busy_o, done_o, reject_o;
    logic [3:0]  force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o;
    logic        tst_clk_o, tst_clr_o, tst_en_o;
    logic [7:0]  tst_din_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rx_phy_bringup #(
        .CLK_KHZ     (CLK_KHZ),
        .CLEAR_US    (CLEAR_US),
        .STEP_CYCLES (STEP)
    ) u_rx_phy_bringup (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .lanes_i      (lanes),
        .rate_mbps_i  (rate),
        .power_off_i  (power_off),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .reject_o     (reject_o),
        .force_rx_o   (force_rx_o),
        .force_stop_o (force_stop_o),
        .turn_req_o   (turn_req_o),
        .turn_dis_o   (turn_dis_o),
        .lane_en_o    (lane_en_o),
        .tst_clk_o    (tst_clk_o),
        .tst_clr_o    (tst_clr_o),
        .tst_en_o     (tst_en_o),
        .tst_din_o    (tst_din_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int i);
        case (i)
            0: return 8'h34;
            1: return 8'h44;
            2: return 8'h54;
            3: return 8'h84;
            4: return 8'h94;
            5: return 8'h75;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(input int i, input logic [6:0] b);
        if (i >= 1 && i <= 4) return {b, 1'b0};
        if (i == 5) return 8'h04;
        return 8'h00;
    endfunction

    function automatic logic [3:0] mask_of(input logic [2:0] n);
        return 4'((5'd1 << n) - 5'd1);
    endfunction

    // Test-port monitor: records code on clock fall and data on clock rise
    logic [7:0] cap_code [0:255];
    logic [7:0] cap_data [0:255];
    int         ntx = 0;
    logic       prev_clk = 1'b0;
    logic [9:0] prev_port = '0;
    int         run = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({tst_clk_o, tst_en_o, tst_din_o} != prev_port) begin
                if (busy_o) chk(run >= STEP, "R7 step hold", run, STEP);
                run = 1;
            end else begin
                run++;
            end
            if (prev_clk && !tst_clk_o) begin
                chk(tst_en_o == 1'b1, "R7 enable high at clock fall", tst_en_o, 1);
                cap_code[ntx & 255] = tst_din_o;
            end
            if (!prev_clk && tst_clk_o && !tst_clr_o) begin
                chk(tst_en_o == 1'b0, "R7 enable low at clock rise", tst_en_o, 0);
                cap_data[ntx & 255] = tst_din_o;
                ntx++;
            end
            prev_clk  = tst_clk_o;
            prev_port = {tst_clk_o, tst_en_o, tst_din_o};
        end
    end

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 5000 && !seen; k++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk(seen, "R8 done pulse seen", seen, 1);
        chk(busy_o == 1'b0, "R8 busy low with done", busy_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done is one cycle", done_o, 0);
    endtask

    task automatic check_script(input int base, input logic [6:0] b);
        chk(ntx - base == 7, "R6 write count", ntx - base, 7);
        for (int i = 0; i < 7; i++) begin
            chk(cap_code[(base + i) & 255] == exp_code(i), "R6 code order",
                cap_code[(base + i) & 255], exp_code(i));
            chk(cap_data[(base + i) & 255] == exp_data(i, b), "R2 R6 data value",
                cap_data[(base + i) & 255], exp_data(i, b));
        end
    endtask

    task automatic pulse_start(input logic [2:0] l, input logic [10:0] r, input bit poff);
        @(negedge clk);
        lanes = l; rate = r; start = 1'b1; power_off = poff;
        @(negedge clk);
        start = 1'b0; power_off = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int  base;
        int  n;
        int  gap;
        bit  seen;
        logic [3:0] len_before;
        base = ntx;
        len_before = lane_en_o;
        pulse_start(v.lanes, v.rate, 1'b0);
        if (!v.accept) begin
            chk(reject_o == 1'b1, "R3 reject pulse", reject_o, 1);
            chk(busy_o == 1'b0, "R3 stays idle", busy_o, 0);
            chk(lane_en_o == len_before, "R3 lane enable untouched", lane_en_o, len_before);
            @(negedge clk);
            chk(reject_o == 1'b0, "R3 reject one cycle", reject_o, 0);
            chk(ntx == base && !tst_clr_o, "R3 test port untouched", ntx - base, 0);
        end else begin
            chk(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
            chk({force_rx_o, force_stop_o, turn_req_o} == 12'h0, "R4 cleared fields",
                {force_rx_o, force_stop_o, turn_req_o}, 0);
            chk(turn_dis_o == 4'hF, "R4 turn disable", turn_dis_o, 4'hF);
            chk(lane_en_o == mask_of(v.lanes), "R4 lane mask", lane_en_o, mask_of(v.lanes));
            chk(tst_clk_o && tst_clr_o, "R4 test clock and clear high",
                {tst_clk_o, tst_clr_o}, 2'b11);
            n = 1;
            for (int k = 0; k < 100000 && tst_clr_o; k++) begin
                @(negedge clk);
                if (tst_clr_o) n++;
            end
            chk(n == WAIT_CYC, "R5 clear width", n, WAIT_CYC);
            gap = 0;
            for (int k = 0; k < 100000 && ntx == base && !tst_en_o && tst_din_o == 8'h00; k++) begin
                gap++;
                @(negedge clk);
            end
            chk(gap >= WAIT_CYC, "R5 wait after clear", gap, WAIT_CYC);
            wait_done(seen);
            check_script(base, v.band);
            chk(lane_en_o == mask_of(v.lanes), "R8 lane mask kept", lane_en_o, mask_of(v.lanes));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int  base;
        bit  seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy_o, done_o, reject_o} == 3'b000, "R1 status low", {busy_o, done_o, reject_o}, 0);
        chk({force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o} == 20'h0,
            "R1 fields zero", {force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o}, 0);
        chk({tst_clk_o, tst_clr_o, tst_en_o, tst_din_o} == 11'h0, "R1 test port zero",
            {tst_clk_o, tst_clr_o, tst_en_o, tst_din_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            repeat (2) @(negedge clk);
        end

        // R10: power-off after a finished sequence
        @(negedge clk);
        power_off = 1'b1;
        @(negedge clk);
        power_off = 1'b0;
        chk(lane_en_o == 4'h0, "R10 power-off clears enables", lane_en_o, 0);

        // R9: start while busy is ignored (lanes 2, 1200 Mbps -> band 0x2b)
        base = ntx;
        pulse_start(3'd2, 11'd1200, 1'b0);
        repeat (20) @(negedge clk);
        pulse_start(3'd4, 11'd89, 1'b0);
        chk(reject_o == 1'b0 && busy_o == 1'b1, "R9 busy start not refused", reject_o, 0);
        chk(lane_en_o == 4'h3, "R9 lane mask unchanged", lane_en_o, 4'h3);
        wait_done(seen);
        check_script(base, 7'h2b);
        chk(lane_en_o == 4'h3, "R9 final lane mask", lane_en_o, 4'h3);

        // R10: power-off in the same cycle as an accepted start
        base = ntx;
        pulse_start(3'd4, 11'd300, 1'b1);
        chk(lane_en_o == 4'h0, "R10 power-off beats start enable", lane_en_o, 0);
        chk(busy_o == 1'b1 && turn_dis_o == 4'hF, "R10 sequence still starts", busy_o, 1);
        wait_done(seen);
        check_script(base, 7'h05);
        chk(lane_en_o == 4'h0, "R10 enables stay cleared", lane_en_o, 0);

        // R10: power-off in the middle of a sequence
        base = ntx;
        pulse_start(3'd3, 11'd1000, 1'b0);
        repeat (10) @(negedge clk);
        power_off = 1'b1;
        @(negedge clk);
        power_off = 1'b0;
        chk(lane_en_o == 4'h0 && busy_o == 1'b1, "R10 mid-run power-off", lane_en_o, 0);
        wait_done(seen);
        check_script(base, 7'h2a);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule